// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block multiplies two 32-bit operands, either both signed or both unsigned as chosen for each operation. It can add an accumulator value to the product and returns a 64-bit result. The multiplier operand is recoded into radix-4 Booth digits. Four digits, which cover 8 multiplier bits, are folded into a redundant sum/carry pair on each of four iteration cycles. A fifth cycle does three things: it resolves the redundant pair in one carry-propagate adder, adds the accumulator term, and applies the correction an unsigned multiplier with its top bit set needs.

A caller drives the operands and mode controls while pulsing `start_i` for one cycle. Exactly five clock edges later `done_o` pulses high for one cycle, and `result_o` then holds the answer until the next accepted operation finishes. Starts that arrive while an operation is in flight are dropped. The answer is always taken modulo 2^64.

Top module: `mac32_iter`

## Requirements
- R1: With `signed_i`=1, both operands are read as two's complement and `result_o` equals the 64-bit signed product plus the selected addend, modulo 2^64.
- R2: With `signed_i`=0, both operands are read as unsigned and `result_o` equals the 64-bit unsigned product plus the selected addend, modulo 2^64.
- R3: With `acc_en_i`=0, the addend is zero and `acc_i` has no effect on `result_o`.
- R4: With `acc_en_i`=1 and `acc_wide_i`=0, the addend is `acc_i[31:0]`. It is sign-extended to 64 bits when `signed_i`=1 and zero-extended when `signed_i`=0. Bits 63:32 of `acc_i` are ignored.
- R5: With `acc_en_i`=1 and `acc_wide_i`=1, the addend is the full 64-bit `acc_i`.
- R6: A start taken in idle makes `done_o` high during exactly the fifth clock cycle after the capturing edge, and `done_o` stays high for only one cycle.
- R7: A `start_i` asserted while an operation is in flight is ignored. The running operation finishes with its own operands, and no extra `done_o` pulse follows.
- R8: `result_o` holds its value from one `done_o` pulse until the next one, whatever the inputs do.
- R9: While reset is asserted and after it is released, `done_o` is 0 and `result_o` is 0 until an operation completes.
- R10: An unsigned multiplier with bit 31 set, including all ones, gives the exact unsigned product. The final cycle adds the multiplicand shifted left by 32 as a correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier (Booth-recoded) |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| acc_en_i | input | 1 | 1: add the accumulator term |
| acc_wide_i | input | 1 | 1: 64-bit addend, 0: 32-bit addend extended per `signed_i` |
| acc_i | input | 64 | Accumulator value |
| result_o | output | 64 | Product plus addend |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The operands are crossed over a corner set in both signedness modes: 0, 1, 2, all ones, the most negative value, the largest positive value and alternating bits. This separates errors in negative Booth digits, in sign extension of partial products and in the unsigned top-bit correction. Because the same bit pattern is read as -1 or as 2^32-1 depending on `signed_i`, a swapped extension shows up at once. Random operands follow. The accumulate settings rotate between off, narrow with random upper bits and wide, which shows whether the upper accumulator bits and the extension of the narrow addend are handled right. The operand inputs are scrambled after capture, and starts are held during a busy period, to show that latched operands and dropped starts behave as the requirements say.

// File: rtl/mac32_pkg.sv
package mac32_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } mac_state_e;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mac_csa3.sv
module mac_csa3 #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);
  logic [W-1:0] maj;

  always_comb begin
    sum_o = x_i ^ y_i ^ z_i;
    maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    // carries weigh one position more: shift before they are used again
    car_o = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mac_booth_pp.sv
module mac_booth_pp #(
  parameter int unsigned W = 64
) (
  input  logic [2:0]   win_i,
  input  logic [W-1:0] mcand_i,
  output logic [W-1:0] pp_o
);
  logic [W-1:0] mag;
  logic         neg;

  always_comb begin
    mag = '0;
    neg = 1'b0;
    unique case (win_i)
      3'b000, 3'b111: begin mag = '0;            neg = 1'b0; end
      3'b001, 3'b010: begin mag = mcand_i;       neg = 1'b0; end
      3'b011:         begin mag = mcand_i << 1;  neg = 1'b0; end
      3'b100:         begin mag = mcand_i << 1;  neg = 1'b1; end
      3'b101, 3'b110: begin mag = mcand_i;       neg = 1'b1; end
      default:        begin mag = '0;            neg = 1'b0; end
    endcase
    // multiplicand is already extended to full width, so the negated
    // partial product carries its sign through every upper bit
    pp_o = neg ? (~mag + W'(1)) : mag;
  end
endmodule

// File: rtl/mac_iter_step.sv
module mac_iter_step #(
  parameter int unsigned W   = 64,
  parameter int unsigned DPC = 4
) (
  input  logic [W-1:0]     sum_i,
  input  logic [W-1:0]     car_i,
  input  logic [W-1:0]     mcand_i,
  input  logic [2*DPC:0]   win_i,
  output logic [W-1:0]     sum_o,
  output logic [W-1:0]     car_o
);
  logic [W-1:0] s_ch [DPC+1];
  logic [W-1:0] c_ch [DPC+1];

  assign s_ch[0] = sum_i;
  assign c_ch[0] = car_i;

  for (genvar k = 0; k < DPC; k++) begin : g_digit
    logic [W-1:0] pp;
    logic [W-1:0] m_sh;
    assign m_sh = mcand_i << (2 * k);

    mac_booth_pp #(.W(W)) u_pp (
      .win_i   (win_i[2*k+2 : 2*k]),
      .mcand_i (m_sh),
      .pp_o    (pp)
    );

    mac_csa3 #(.W(W)) u_csa (
      .x_i   (s_ch[k]),
      .y_i   (c_ch[k]),
      .z_i   (pp),
      .sum_o (s_ch[k+1]),
      .car_o (c_ch[k+1])
    );
  end

  assign sum_o = s_ch[DPC];
  assign car_o = c_ch[DPC];
endmodule

// File: rtl/mac_final.sv
module mac_final #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] car_i,
  input  logic [W-1:0] fix_term_i,
  input  logic         fix_en_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] corr;
  logic [W-1:0] s1, c1, s2, c2;

  assign corr = fix_en_i ? fix_term_i : '0;

  mac_csa3 #(.W(W)) u_csa_fix (
    .x_i(sum_i), .y_i(car_i), .z_i(corr), .sum_o(s1), .car_o(c1)
  );

  mac_csa3 #(.W(W)) u_csa_acc (
    .x_i(s1), .y_i(c1), .z_i(addend_i), .sum_o(s2), .car_o(c2)
  );

  assign res_o = s2 + c2;
endmodule

// File: rtl/mac32_iter.sv
module mac32_iter
  import mac32_pkg::*;
#(
  parameter int unsigned OPW = 32,
  parameter int unsigned DPC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       op_a_i,
  input  logic [31:0]       op_b_i,
  input  logic              signed_i,
  input  logic              acc_en_i,
  input  logic              acc_wide_i,
  input  logic [63:0]       acc_i,
  output logic [63:0]       result_o,
  output logic              done_o
);
  localparam int unsigned RW   = 2 * OPW;
  localparam int unsigned BPC  = 2 * DPC;
  localparam int unsigned NCYC = OPW / BPC;
  localparam int unsigned CW   = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(NCYC - 1);

  logic rst_n_s;

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  mac_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;
  logic [RW-1:0] result_q;

  logic [RW-1:0]  a_q;
  logic [OPW-1:0] b_q;
  logic           bprev_q;
  logic           fix_q;
  logic [RW-1:0]  add_q;
  logic [RW-1:0]  sum_q, car_q;

  logic           load_en, iter_en, fin_en;
  logic [RW-1:0]  a_ext, addend_in, narrow_ext;
  logic [BPC:0]   win;
  logic [RW-1:0]  step_s, step_c, fin_res;

  // operand and addend shaping at capture
  always_comb begin
    a_ext      = signed_i ? {{(RW-OPW){op_a_i[OPW-1]}}, op_a_i}
                          : {{(RW-OPW){1'b0}}, op_a_i};
    narrow_ext = signed_i ? {{(RW-OPW){acc_i[OPW-1]}}, acc_i[OPW-1:0]}
                          : {{(RW-OPW){1'b0}}, acc_i[OPW-1:0]};
    if (!acc_en_i)      addend_in = '0;
    else if (acc_wide_i) addend_in = acc_i;
    else                 addend_in = narrow_ext;
  end

  // next-state logic and clock enables
  always_comb begin
    load_en = (state_q == ST_IDLE) && start_i;
    iter_en = (state_q == ST_RUN);
    fin_en  = (state_q == ST_FINAL);
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CNT_LAST) state_d = ST_FINAL;
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign win = {b_q[BPC-1:0], bprev_q};

  mac_iter_step #(.W(RW), .DPC(DPC)) u_step (
    .sum_i   (sum_q),
    .car_i   (car_q),
    .mcand_i (a_q),
    .win_i   (win),
    .sum_o   (step_s),
    .car_o   (step_c)
  );

  // after NCYC shifts a_q equals the multiplicand shifted by OPW,
  // which is exactly the unsigned top-bit correction term
  mac_final #(.W(RW)) u_final (
    .sum_i      (sum_q),
    .car_i      (car_q),
    .fix_term_i (a_q),
    .fix_en_i   (fix_q),
    .addend_i   (add_q),
    .res_o      (fin_res)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= fin_en;
      if (fin_en) result_q <= fin_res;
    end
  end

  // datapath registers (no reset needed)
  always_ff @(posedge clk) begin
    if (load_en) begin
      a_q     <= a_ext;
      b_q     <= op_b_i;
      bprev_q <= 1'b0;
      fix_q   <= !signed_i && op_b_i[OPW-1];
      add_q   <= addend_in;
      sum_q   <= '0;
      car_q   <= '0;
    end else if (iter_en) begin
      a_q     <= a_q << BPC;
      b_q     <= b_q >> BPC;
      bprev_q <= b_q[BPC-1];
      sum_q   <= step_s;
      car_q   <= step_c;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R6: an idle start always moves into the iteration phase
  assert_start_taken_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_RUN && cnt_q == '0));

  // R6: iteration counter advances by one each busy cycle
  assert_iter_advance_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_RUN && cnt_q != CNT_LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + CW'(1)));

  // R6: done is a single-cycle pulse following the final stage
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  assert_done_after_final_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> ($past(state_q) == ST_FINAL));

  // R7: a start seen in the final stage does not restart the unit
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FINAL) |=> (state_q == ST_IDLE));

  // R8: result only changes on the completion edge
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_FINAL) |=> $stable(result_o));
endmodule

// File: tb/sim_mac32_iter.sv
module sim_mac32_iter;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i, op_b_i;
  logic        signed_i, acc_en_i, acc_wide_i;
  logic [63:0] acc_i;
  logic [63:0] result_o;
  logic        done_o;

  int n_chk;
  int n_fail;
  int cyc;
  logic [31:0] lcg;

  mac32_iter u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .signed_i(signed_i),
    .acc_en_i(acc_en_i), .acc_wide_i(acc_wide_i), .acc_i(acc_i),
    .result_o(result_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg ^ (lcg >> 13);
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic s, input logic en, input logic wd,
                                        input logic [63:0] acc);
    logic [63:0] ea, eb, ad;
    ea = s ? {{32{a[31]}}, a} : {32'd0, a};
    eb = s ? {{32{b[31]}}, b} : {32'd0, b};
    if (!en)     ad = 64'd0;
    else if (wd) ad = acc;
    else         ad = s ? {{32{acc[31]}}, acc[31:0]} : {32'd0, acc[31:0]};
    return ea * eb + ad;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic en, input logic wd, input logic [63:0] acc);
    logic [63:0] exp;
    string tg;
    int k;
    exp = model(a, b, s, en, wd, acc);
    tg = s ? "R1" : ((b[31]) ? "R2/R10" : "R2");
    if (!en)     tg = {tg, " R3"};
    else if (wd) tg = {tg, " R5"};
    else         tg = {tg, " R4"};
    @(negedge clk);
    op_a_i = a; op_b_i = b; signed_i = s; acc_en_i = en; acc_wide_i = wd;
    acc_i = acc; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    op_a_i = ~a; op_b_i = b ^ 32'h1234_5678; signed_i = ~s; acc_i = ~acc;
    acc_en_i = ~en; acc_wide_i = ~wd;
    k = 0;
    while (!done_o && k < 20) begin
      @(posedge clk); k++; @(negedge clk);
    end
    chk(k == 5, "R6 latency", 64'(k), 64'd5);
    chk(result_o == exp, tg, result_o, exp);
    @(posedge clk); @(negedge clk);
    chk(done_o == 1'b0, "R6 single pulse", 64'(done_o), 64'd0);
    chk(result_o == exp, "R8 hold", result_o, exp);
  endtask

  logic [31:0] corners [8];

  initial begin
    logic [63:0] exp1;
    int k;
    bit extra_done;
    bit moved;
    n_chk = 0; n_fail = 0; cyc = 0; lcg = 32'h2468_ace1;
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h0000_0002; corners[3] = 32'hFFFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h7FFF_FFFF;
    corners[6] = 32'h5555_5555; corners[7] = 32'hAAAA_AAAB;
    start_i = 0; op_a_i = 0; op_b_i = 0; signed_i = 0; acc_en_i = 0;
    acc_wide_i = 0; acc_i = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done in reset", 64'(done_o), 64'd0);
    chk(result_o == 64'd0, "R9 result in reset", result_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done after reset", 64'(done_o), 64'd0);
    chk(result_o == 64'd0, "R9 result after reset", result_o, 64'd0);

    // corner sweep, both modes, rotating accumulate settings
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 2; s++) begin
          int m;
          m = (i + j + s) % 3;
          run_op(corners[i], corners[j], s[0], m != 0, m == 2,
                 {rnd(), rnd()});
        end

    // random operands
    for (int r = 0; r < 300; r++) begin
      int m;
      m = r % 3;
      run_op(rnd(), rnd(), r[1], m != 0, m == 2, {rnd(), rnd()});
    end

    // R7: starts held during busy are ignored
    exp1 = model(32'd7, 32'hFFFF_FFFD, 1'b1, 1'b0, 1'b0, 64'd0);
    @(negedge clk);
    op_a_i = 32'd7; op_b_i = 32'hFFFF_FFFD; signed_i = 1'b1;
    acc_en_i = 1'b0; acc_wide_i = 1'b0; acc_i = 64'd0; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_a_i = 32'd99; op_b_i = 32'd99; acc_en_i = 1'b1; acc_wide_i = 1'b1;
    acc_i = 64'd5;
    k = 0;
    while (!done_o && k < 20) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (k == 3) start_i = 1'b0;
    end
    chk(k == 5, "R7 latency with busy start", 64'(k), 64'd5);
    chk(result_o == exp1, "R7 busy start ignored", result_o, exp1);
    start_i = 1'b0;
    extra_done = 1'b0;
    moved = 1'b0;
    for (int t = 0; t < 8; t++) begin
      @(posedge clk); @(negedge clk);
      if (done_o) extra_done = 1'b1;
      if (result_o != exp1) moved = 1'b1;
    end
    chk(!extra_done, "R7 no extra done", 64'(extra_done), 64'd0);
    chk(!moved, "R8 result held while idle", result_o, exp1);

    // R4: upper accumulator bits ignored in narrow mode
    run_op(32'h0000_0003, 32'h0000_0005, 1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_0000_0010);
    run_op(32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1, 1'b0, 64'h1234_5678_FFFF_FFF0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule